// File: doc/BRIEF.md
# Vector Element Swizzle Unit

This block reorders the elements of short vectors (two, three or four 32-bit single-precision elements) for two source operands before they reach an arithmetic unit. Each operand has its own control word. For every destination lane, that word either picks any element of its source vector, keeps the lane's previous destination value, or supplies one of four floating-point constants. Picking any element lets a lane read across lanes, and several lanes may read the same element to broadcast it.

A single prior-destination vector is shared by both operands. It supplies the value for every lane that is masked off or that lies beyond the active vector length. The results are captured in output registers when the input strobe is high and held otherwise, so they appear one cycle after the strobe together with a valid flag.

Top module: `vec_swizzle_unit`

## Requirements
- R1: `vlen_i` gives the active element count (2, 3 or 4). Every destination lane whose index is at or above `vlen_i` outputs the matching lane of `prior_i`, whatever its control bits say.
- R2: Lane k of a control word uses bits [3k+2:3k]. Bits [3k+1:3k] are a selector that copies source element 0 to 3 into lane k, in any order. Element j occupies bits [32j+31:32j] of each vector.
- R3: Several lanes may carry the same selector, and each of them then receives that one source element.
- R4: Bit 3k+2 of a control word is the write enable for lane k. When it is 0, the lane outputs the matching lane of `prior_i`.
- R5: When constant flag bit k is 1 for an enabled, in-range lane, the selector chooses a constant instead of a source element: 0 gives 0x00000000, 1 gives 0x3F800000, 2 gives 0xBF800000 and 3 gives 0x3F000000.
- R6: An enabled, in-range, non-constant lane whose selector is at or above `vlen_i` outputs 0x00000000.
- R7: Operand A uses only `src_a_i`, `ctl_a_i` and `cst_a_i`. Operand B uses only `src_b_i`, `ctl_b_i` and `cst_b_i`. The two are independent.
- R8: The results for the inputs present at a clock edge with `in_valid_i` high appear on `out_a_o` and `out_b_o` after that edge. `out_valid_o` equals `in_valid_i` delayed by one cycle.
- R9: At a clock edge with `in_valid_i` low, `out_a_o` and `out_b_o` keep their values.
- R10: While `rst_n` is low, both output vectors and `out_valid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input strobe and output-register load enable |
| vlen_i | input | 3 | Active element count, 2 to 4 |
| src_a_i | input | 128 | Source vector, operand A |
| src_b_i | input | 128 | Source vector, operand B |
| ctl_a_i | input | 12 | Per-lane enable and selector, operand A |
| ctl_b_i | input | 12 | Per-lane enable and selector, operand B |
| cst_a_i | input | 4 | Per-lane constant flags, operand A |
| cst_b_i | input | 4 | Per-lane constant flags, operand B |
| prior_i | input | 128 | Prior destination vector, shared by both operands |
| out_a_o | output | 128 | Swizzled result, operand A |
| out_b_o | output | 128 | Swizzled result, operand B |
| out_valid_o | output | 1 | Results valid |

## Verification
The assertions assume that `vlen_i` holds only 2, 3 or 4, and that `in_valid_i` is low while reset is asserted. The reset-release checks depend on that second condition. The stimulus keeps to both: every directed and random case draws the vector length from the legal set, and the strobe is raised only after reset has been released. Inputs change on the falling clock edge, so they are stable at every rising edge where the checks sample them.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int unsigned ELEM_W = 32;
  localparam int unsigned LANES  = 4;

  // Constant code table: 0.0, 1.0, -1.0, 0.5
  function automatic logic [31:0] const_word(input logic [1:0] code);
    logic [31:0] w;
    case (code)
      2'd0:    w = 32'h0000_0000;
      2'd1:    w = 32'h3F80_0000;
      2'd2:    w = 32'hBF80_0000;
      default: w = 32'h3F00_0000;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/swz_lane.sv
module swz_lane #(
  parameter int unsigned EW       = 32,
  parameter int unsigned NL       = 4,
  parameter int unsigned LANE_IDX = 0,
  localparam int unsigned SW      = $clog2(NL),
  localparam int unsigned VW      = $clog2(NL + 1)
) (
  input  logic [NL*EW-1:0] src_i,
  input  logic [SW-1:0]    sel_i,
  input  logic             wen_i,
  input  logic             cst_i,
  input  logic [VW-1:0]    vlen_i,
  input  logic [EW-1:0]    prior_i,
  output logic [EW-1:0]    res_o
);
  logic [EW-1:0] elems [NL];
  logic          lane_live;

  for (genvar j = 0; j < NL; j++) begin : g_unpack
    assign elems[j] = src_i[j*EW +: EW];
  end

  assign lane_live = (VW'(LANE_IDX) < vlen_i) && wen_i;

  always_comb begin
    res_o = prior_i;
    if (lane_live) begin
      if (cst_i)
        res_o = EW'(swz_pkg::const_word(2'(sel_i)));
      else if (VW'(sel_i) < vlen_i)
        res_o = elems[sel_i];
      else
        res_o = '0;
    end
  end
endmodule

// File: rtl/swz_operand.sv
module swz_operand #(
  parameter int unsigned EW  = 32,
  parameter int unsigned NL  = 4,
  localparam int unsigned SW = $clog2(NL),
  localparam int unsigned FW = SW + 1,
  localparam int unsigned CW = NL * FW,
  localparam int unsigned VW = $clog2(NL + 1)
) (
  input  logic [NL*EW-1:0] src_i,
  input  logic [CW-1:0]    ctl_i,
  input  logic [NL-1:0]    cst_i,
  input  logic [VW-1:0]    vlen_i,
  input  logic [NL*EW-1:0] prior_i,
  output logic [NL*EW-1:0] res_o
);
  for (genvar k = 0; k < NL; k++) begin : g_lane
    swz_lane #(.EW(EW), .NL(NL), .LANE_IDX(k)) lane_i (
      .src_i  (src_i),
      .sel_i  (ctl_i[k*FW +: SW]),
      .wen_i  (ctl_i[k*FW + SW]),
      .cst_i  (cst_i[k]),
      .vlen_i (vlen_i),
      .prior_i(prior_i[k*EW +: EW]),
      .res_o  (res_o[k*EW +: EW])
    );
  end
endmodule

// File: rtl/vec_swizzle_unit.sv
module vec_swizzle_unit #(
  parameter int unsigned EW  = swz_pkg::ELEM_W,
  parameter int unsigned NL  = swz_pkg::LANES,
  localparam int unsigned SW = $clog2(NL),
  localparam int unsigned CW = NL * (SW + 1),
  localparam int unsigned VW = $clog2(NL + 1),
  localparam int unsigned DW = NL * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic [VW-1:0] vlen_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  input  logic [CW-1:0] ctl_a_i,
  input  logic [CW-1:0] ctl_b_i,
  input  logic [NL-1:0] cst_a_i,
  input  logic [NL-1:0] cst_b_i,
  input  logic [DW-1:0] prior_i,
  output logic [DW-1:0] out_a_o,
  output logic [DW-1:0] out_b_o,
  output logic          out_valid_o
);
  logic [DW-1:0] swz_a, swz_b;
  logic [DW-1:0] a_q, a_d, b_q, b_d;
  logic          v_q, v_d;

  swz_operand #(.EW(EW), .NL(NL)) op_a_i (
    .src_i(src_a_i), .ctl_i(ctl_a_i), .cst_i(cst_a_i),
    .vlen_i(vlen_i), .prior_i(prior_i), .res_o(swz_a)
  );

  swz_operand #(.EW(EW), .NL(NL)) op_b_i (
    .src_i(src_b_i), .ctl_i(ctl_b_i), .cst_i(cst_b_i),
    .vlen_i(vlen_i), .prior_i(prior_i), .res_o(swz_b)
  );

  // Next-state: load on strobe, otherwise hold
  always_comb begin
    a_d = a_q;
    b_d = b_q;
    v_d = in_valid_i;
    if (in_valid_i) begin
      a_d = swz_a;
      b_d = swz_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      v_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      v_q <= v_d;
    end
  end

  assign out_a_o     = a_q;
  assign out_b_o     = b_q;
  assign out_valid_o = v_q;

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> out_valid_o);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !out_valid_o);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ($stable(out_a_o) && $stable(out_b_o)));
  // R4
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && !ctl_a_i[SW]) |=> out_a_o[EW-1:0] == $past(prior_i[EW-1:0]));
  // R1
  top_lane_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && vlen_i < VW'(NL)) |=> out_b_o[DW-1 -: EW] == $past(prior_i[DW-1 -: EW]));
endmodule

// File: tb/vec_swizzle_unit_tb.sv
module vec_swizzle_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   vlen;
  logic [127:0] src_a, src_b, prior;
  logic [11:0]  ctl_a, ctl_b;
  logic [3:0]   cst_a, cst_b;
  logic [127:0] out_a, out_b;
  logic         out_valid;

  int errors = 0;
  int checks = 0;
  string cur_tag = "R10";
  string exp_tag = "R10";
  logic [127:0] exp_a = '0, exp_b = '0;
  logic         exp_v = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_swizzle_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .vlen_i(vlen),
    .src_a_i(src_a), .src_b_i(src_b), .ctl_a_i(ctl_a), .ctl_b_i(ctl_b),
    .cst_a_i(cst_a), .cst_b_i(cst_b), .prior_i(prior),
    .out_a_o(out_a), .out_b_o(out_b), .out_valid_o(out_valid)
  );

  function automatic logic [127:0] model(input logic [127:0] src, input logic [11:0] ctl,
                                         input logic [3:0] cst, input int n,
                                         input logic [127:0] pri);
    logic [127:0] r;
    logic [31:0] k_tab [4];
    k_tab[0] = 32'h0000_0000; k_tab[1] = 32'h3F80_0000;
    k_tab[2] = 32'hBF80_0000; k_tab[3] = 32'h3F00_0000;
    r = pri;
    for (int k = 0; k < 4; k++) begin
      int s;
      s = int'(ctl[3*k +: 2]);
      if (k < n && ctl[3*k+2]) begin
        if (cst[k])     r[32*k +: 32] = k_tab[s];
        else if (s < n) r[32*k +: 32] = src[32*s +: 32];
        else            r[32*k +: 32] = 32'h0;
      end
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_a <= '0; exp_b <= '0; exp_v <= 1'b0; exp_tag <= "R10";
    end else begin
      exp_v   <= in_valid;
      exp_tag <= cur_tag;
      if (in_valid) begin
        exp_a <= model(src_a, ctl_a, cst_a, int'(vlen), prior);
        exp_b <= model(src_b, ctl_b, cst_b, int'(vlen), prior);
      end
    end
  end

  task automatic compare();
    checks++;
    if (out_a !== exp_a || out_b !== exp_b || out_valid !== exp_v) begin
      errors++;
      $display("FAIL %s: a=%h b=%h v=%b expected a=%h b=%h v=%b",
               exp_tag, out_a, out_b, out_valid, exp_a, exp_b, exp_v);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [2:0] n,
                      input logic [11:0] ca, input logic [11:0] cb,
                      input logic [3:0] ka, input logic [3:0] kb);
    @(negedge clk);
    compare();
    cur_tag = tag; in_valid = v; vlen = n;
    ctl_a = ca; ctl_b = cb; cst_a = ka; cst_b = kb;
  endtask

  // lane field helper: {wen, sel}
  function automatic logic [11:0] f4(input logic [2:0] l3, input logic [2:0] l2,
                                     input logic [2:0] l1, input logic [2:0] l0);
    return {l3, l2, l1, l0};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; vlen = 3'd4;
    ctl_a = '0; ctl_b = '0; cst_a = '0; cst_b = '0;
    src_a = {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
    src_b = {32'hB3B3_0003, 32'hB2B2_0002, 32'hB1B1_0001, 32'hB0B0_0000};
    prior = {32'hD3D3_0003, 32'hD2D2_0002, 32'hD1D1_0001, 32'hD0D0_0000};
    repeat (3) @(negedge clk);
    compare(); // R10 reset state
    rst_n = 1'b1;
    // R2 reversal, R7 with B identity
    step("R2", 1, 3'd4, f4(3'b100,3'b101,3'b110,3'b111), f4(3'b111,3'b110,3'b101,3'b100), 4'h0, 4'h0);
    // R3 broadcast element 2 / element 0
    step("R3", 1, 3'd4, f4(3'b110,3'b110,3'b110,3'b110), f4(3'b100,3'b100,3'b100,3'b100), 4'h0, 4'h0);
    // R4 mask pattern
    step("R4", 1, 3'd4, f4(3'b011,3'b111,3'b001,3'b101), f4(3'b111,3'b000,3'b110,3'b001), 4'h0, 4'h0);
    // R5 all constant codes
    step("R5", 1, 3'd4, f4(3'b111,3'b110,3'b101,3'b100), f4(3'b101,3'b101,3'b101,3'b101), 4'hF, 4'h4);
    // R6 selector beyond length
    step("R6", 1, 3'd2, f4(3'b111,3'b111,3'b111,3'b110), f4(3'b100,3'b100,3'b101,3'b111), 4'h0, 4'h0);
    // R1 length 3 and 2
    step("R1", 1, 3'd3, f4(3'b100,3'b100,3'b100,3'b100), f4(3'b101,3'b101,3'b101,3'b101), 4'h8, 4'h8);
    step("R1", 1, 3'd2, f4(3'b101,3'b101,3'b101,3'b101), f4(3'b100,3'b100,3'b100,3'b100), 4'hC, 4'h0);
    // R7 different constants and masks per operand
    step("R7", 1, 3'd4, f4(3'b111,3'b010,3'b101,3'b100), f4(3'b000,3'b111,3'b110,3'b101), 4'h1, 4'h6);
    // R9 hold while idle with changing inputs
    step("R9", 0, 3'd4, 12'hFFF, 12'hFFF, 4'hF, 4'hF);
    prior = ~prior;
    step("R9", 0, 3'd3, 12'h000, 12'h000, 4'h0, 4'h0);
    step("R9", 0, 3'd2, 12'h924, 12'h924, 4'h0, 4'h0);
    // R8 alternating strobe
    for (int i = 0; i < 8; i++)
      step("R8", logic'(i % 2), 3'd4, 12'(12'h924 + i), 12'(12'hB6D - i), 4'h0, 4'h0);
    // R2 random mix
    for (int i = 0; i < 300; i++) begin
      src_a = {$urandom, $urandom, $urandom, $urandom};
      src_b = {$urandom, $urandom, $urandom, $urandom};
      prior = {$urandom, $urandom, $urandom, $urandom};
      step("R2", logic'($urandom_range(0, 3) != 0), 3'($urandom_range(2, 4)),
           12'($urandom), 12'($urandom), 4'($urandom), 4'($urandom));
    end
    step("R8", 0, 3'd4, '0, '0, '0, '0);
    step("R9", 0, 3'd4, '0, '0, '0, '0);
    // R10 reset in mid-run clears outputs
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    #1;
    exp_tag = "R10";
    compare();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule